// File: doc/BRIEF.md
# Message Object Flag Control

This block holds the control state of one CAN message object: eight single-bit flags that the CPU and the protocol engine both modify. The CPU never writes a flag as a plain bit. Every flag is reached through a two-bit code, so a single byte write can set some flags, clear others and leave the rest untouched. As a result, software never needs a read-modify-write sequence that could race with hardware updates. A small configuration byte with the frame length, the direction and the identifier format sits next to the flags. The direction bit decides what one of the shared flag slots means.

The protocol engine reports three kinds of event as one-cycle pulses: a frame was stored into the object, a frame from the object was sent, and a remote frame matched the object. The block turns these pulses into flag updates and raises an interrupt flag when the matching interrupt enable is set. It also tells the engine when a transmission may start. The block has no streaming data path. All pins are plain control and status signals, sampled on the rising clock edge, and there is no back-pressure.

Top module: `msgobj_ctrl`

## Requirements
- R1: After reset all eight flags are clear and the configuration byte is zero, so control bytes 0 and 1 each read 0x55, the configuration reads 0x00, and irq and tx_go are low.
- R2: In a CPU write each two-bit pair acts on its own flag: code 01 clears it, code 10 sets it, and codes 11 and 00 leave it as it was. The result is visible on the cycle after the write.
- R3: cpu_addr selects the register: 0 is control byte 0, 1 is control byte 1, 2 is the configuration byte, and 3 reads 0x00. The configuration byte holds the frame length in bits [7:4], direction-transmit in bit 3 and extended identifier in bit 2. Bits [1:0] read 0.
- R4: Pair positions, low pair first, are as follows. Control byte 0 holds interrupt pending [1:0], receive interrupt enable [3:2], transmit interrupt enable [5:4] and message valid [7:6]. Control byte 1 holds new data [1:0], message lost / CPU updating [3:2], transmit request [5:4] and remote pending [7:6]. A read returns 10 in a pair whose flag is set and 01 in a pair whose flag is clear.
- R5: A received frame sets new data. If new data was already set and the direction is receive, it also sets message lost. It sets interrupt pending only when receive interrupts are enabled.
- R6: When the direction is transmit, the shared pair means CPU updating, and a received frame never changes it.
- R7: A completed transmission clears transmit request. It sets interrupt pending only when transmit interrupts are enabled.
- R8: A matching remote frame sets remote pending. It sets interrupt pending only when receive interrupts are enabled.
- R9: tx_go is high exactly when message valid, direction-transmit and transmit request are all set and CPU updating is clear.
- R10: All three hardware events are ignored while message valid is clear.
- R11: When a CPU write and a hardware event target the same flag in the same cycle, the write decides the flag unless its code for that pair is 11 or 00, in which case the event takes effect.
- R12: irq follows the interrupt pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 2 | Register select for read and write |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Read byte for cpu_addr, combinational |
| ev_rx | input | 1 | Frame received into this object |
| ev_tx_done | input | 1 | Frame from this object sent successfully |
| ev_remote | input | 1 | Remote frame matched this object |
| irq | output | 1 | Interrupt pending flag |
| tx_go | output | 1 | Transmission may be started |

## Verification
All 256 write codes are swept into both control bytes, once from an all-clear state and once from an all-set state. This separates the set, clear and keep actions of each pair and shows that a code in one pair never leaks into its neighbour. All sixteen combinations of message valid, direction, transmit request and CPU updating are also swept against tx_go. Event sequences are then run with each interrupt enable on and off, and with the direction switched both ways. These runs separate overrun detection from plain reception, and an invalid object from a valid one. Same-cycle collisions between a write and an event show which source wins for a real code and which wins for a keep code.

// File: rtl/msgobj_pkg.sv
package msgobj_pkg;
  localparam int NFLAG = 8;
  localparam int PAIRS = 4;

  // flag slots, low pair of control byte 0 first
  localparam int F_IPND = 0;
  localparam int F_RXIE = 1;
  localparam int F_TXIE = 2;
  localparam int F_MVAL = 3;
  localparam int F_NDAT = 4;
  localparam int F_LOST = 5;
  localparam int F_TXRQ = 6;
  localparam int F_RMTP = 7;

  localparam logic [1:0] PC_CLR = 2'b01;
  localparam logic [1:0] PC_SET = 2'b10;

  localparam logic [1:0] REG_CTL0 = 2'd0;
  localparam logic [1:0] REG_CTL1 = 2'd1;
  localparam logic [1:0] REG_CFG  = 2'd2;

  function automatic logic [7:0] pair_encode(input logic [3:0] f);
    logic [7:0] r;
    for (int k = 0; k < PAIRS; k++) r[2*k +: 2] = f[k] ? PC_SET : PC_CLR;
    return r;
  endfunction
endpackage

// File: rtl/pairflag_cell.sv
module pairflag_cell
  import msgobj_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_hit,
  input  logic [1:0] code,
  input  logic       hw_set,
  input  logic       hw_clr,
  output logic       q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                        q <= RST_VAL;
    else if (cpu_hit && code == PC_SET) q <= 1'b1;
    else if (cpu_hit && code == PC_CLR) q <= 1'b0;
    else if (hw_set)                   q <= 1'b1;
    else if (hw_clr)                   q <= 1'b0;
  end
endmodule

// File: rtl/msgobj_evt.sv
module msgobj_evt
  import msgobj_pkg::*;
(
  input  logic [NFLAG-1:0] flags,
  input  logic             dir_tx,
  input  logic             ev_rx,
  input  logic             ev_tx_done,
  input  logic             ev_remote,
  output logic [NFLAG-1:0] hw_set,
  output logic [NFLAG-1:0] hw_clr
);
  logic live;
  assign live = flags[F_MVAL];

  always_comb begin
    hw_set = '0;
    hw_clr = '0;
    hw_set[F_NDAT] = live & ev_rx;
    hw_set[F_LOST] = live & ev_rx & flags[F_NDAT] & ~dir_tx;
    hw_set[F_RMTP] = live & ev_remote;
    hw_set[F_IPND] = live & (((ev_rx | ev_remote) & flags[F_RXIE]) |
                             (ev_tx_done & flags[F_TXIE]));
    hw_clr[F_TXRQ] = live & ev_tx_done;
  end
endmodule

// File: rtl/msgobj_ctrl.sv
module msgobj_ctrl
  import msgobj_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DLC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              ev_rx,
  input  logic              ev_tx_done,
  input  logic              ev_remote,
  output logic              irq,
  output logic              tx_go
);
  localparam int CFG_LO = 8 - DLC_W;

  logic [NFLAG-1:0] flags, hw_set, hw_clr;
  logic [DLC_W-1:0] cfg_dlc;
  logic             cfg_dir, cfg_xtd;
  logic             wr0, wr1;

  assign wr0 = cpu_we && cpu_addr == ADDR_W'(REG_CTL0);
  assign wr1 = cpu_we && cpu_addr == ADDR_W'(REG_CTL1);

  msgobj_evt u_evt (
    .flags(flags), .dir_tx(cfg_dir), .ev_rx(ev_rx), .ev_tx_done(ev_tx_done),
    .ev_remote(ev_remote), .hw_set(hw_set), .hw_clr(hw_clr)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    pairflag_cell #(.RST_VAL(1'b0)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .cpu_hit(cpu_we && cpu_addr == ADDR_W'(i / PAIRS)),
      .code(cpu_wdata[2*(i % PAIRS) +: 2]),
      .hw_set(hw_set[i]), .hw_clr(hw_clr[i]), .q(flags[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_dlc <= '0;
      cfg_dir <= 1'b0;
      cfg_xtd <= 1'b0;
    end else if (cpu_we && cpu_addr == ADDR_W'(REG_CFG)) begin
      cfg_dlc <= cpu_wdata[7:CFG_LO];
      cfg_dir <= cpu_wdata[3];
      cfg_xtd <= cpu_wdata[2];
    end
  end

  always_comb begin
    case (cpu_addr)
      ADDR_W'(REG_CTL0): cpu_rdata = pair_encode(flags[3:0]);
      ADDR_W'(REG_CTL1): cpu_rdata = pair_encode(flags[7:4]);
      ADDR_W'(REG_CFG):  cpu_rdata = {cfg_dlc, cfg_dir, cfg_xtd, 2'b00};
      default:           cpu_rdata = 8'h00;
    endcase
  end

  assign irq   = flags[F_IPND];
  assign tx_go = flags[F_MVAL] & cfg_dir & flags[F_TXRQ] & ~flags[F_LOST];

  AST_KEEP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr0 && cpu_wdata == 8'hFF && !ev_rx && !ev_tx_done && !ev_remote |=> $stable(flags[3:0])); // R2
  AST_RX_NEWDAT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx && flags[F_MVAL] && !wr1 |=> flags[F_NDAT]); // R5
  AST_OVERRUN_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx && flags[F_MVAL] && flags[F_NDAT] && !cfg_dir && !wr1 |=> flags[F_LOST]); // R5
  AST_TXDONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_done && flags[F_MVAL] && !wr1 |=> !flags[F_TXRQ]); // R7
  AST_INVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[F_MVAL] && !cpu_we |=> $stable(flags)); // R10
  AST_CPU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr1 && cpu_wdata[1:0] == PC_CLR |=> !flags[F_NDAT]); // R11
endmodule

// File: tb/msgobj_ctrl_test.sv
module msgobj_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_we = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic ev_rx = 1'b0, ev_tx_done = 1'b0, ev_remote = 1'b0;
  logic irq, tx_go;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  msgobj_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ev_rx(ev_rx),
    .ev_tx_done(ev_tx_done), .ev_remote(ev_remote), .irq(irq), .tx_go(tx_go)
  );

  function automatic logic [7:0] enc(input logic [3:0] f);
    logic [7:0] r;
    for (int k = 0; k < 4; k++) r[2*k +: 2] = f[k] ? 2'b10 : 2'b01;
    return r;
  endfunction

  function automatic logic [3:0] apply(input logic [3:0] old, input logic [7:0] w);
    logic [3:0] r;
    for (int k = 0; k < 4; k++)
      r[k] = (w[2*k +: 2] == 2'b10) ? 1'b1 : (w[2*k +: 2] == 2'b01) ? 1'b0 : old[k];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d,
                      input logic rx, input logic tx, input logic rm);
    @(negedge clk);
    cpu_we = we; cpu_addr = a; cpu_wdata = d;
    ev_rx = rx; ev_tx_done = tx; ev_remote = rm;
    @(negedge clk);
    cpu_we = 1'b0; ev_rx = 1'b0; ev_tx_done = 1'b0; ev_remote = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    cpu_addr = a;
    #1;
    v = cpu_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); chk("R1 ctl0", v, 8'h55);
    rd(2'd1, v); chk("R1 ctl1", v, 8'h55);
    rd(2'd2, v); chk("R1 cfg", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 tx_go", {7'd0, tx_go}, 8'h00);

    // R2 / R4 sweep of every code from both prior states
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 2; a++) begin
        for (int w = 0; w < 256; w++) begin
          logic [3:0] prior;
          prior = (p == 1) ? 4'hF : 4'h0;
          wr(2'(a), enc(prior));
          wr(2'(a), 8'(w));
          rd(2'(a), v);
          chk("R2 R4 code sweep", v, enc(apply(prior, 8'(w))));
        end
      end
    end
    wr(2'd0, 8'h55); wr(2'd1, 8'h55);

    // R10 events ignored while invalid
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1);
    rd(2'd1, v); chk("R10 ctl1", v, 8'h55);
    chk("R10 irq", {7'd0, irq}, 8'h00);

    // R5 / R12 reception with rx interrupts on
    wr(2'd0, 8'h99);
    rd(2'd0, v); chk("R4 ctl0 setup", v, 8'h99);
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    rd(2'd1, v); chk("R5 newdat", v, 8'h56);
    chk("R12 irq rx", {7'd0, irq}, 8'h01);
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    rd(2'd1, v); chk("R5 overrun lost", v, 8'h5A);
    wr(2'd1, 8'h55); wr(2'd0, 8'hFD);
    chk("R12 irq cleared", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h95);
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R5 no irq rxie off", {7'd0, irq}, 8'h00);
    rd(2'd1, v); chk("R5 newdat rxie off", v, 8'h56);

    // R6 transmit direction, shared pair untouched by overrun
    wr(2'd2, 8'h38);
    rd(2'd2, v); chk("R3 cfg", v, 8'h38);
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    rd(2'd1, v); chk("R6 no lost", v, 8'h56);

    // R3 map
    wr(2'd2, 8'hF7);
    rd(2'd2, v); chk("R3 cfg low bits", v, 8'hF4);
    rd(2'd3, v); chk("R3 addr3", v, 8'h00);
    wr(2'd2, 8'h08);

    // R9 start gating
    wr(2'd1, 8'hEF);
    chk("R9 go", {7'd0, tx_go}, 8'h01);
    wr(2'd1, 8'hFB);
    chk("R9 held by updating", {7'd0, tx_go}, 8'h00);
    wr(2'd1, 8'hF7);
    chk("R9 released", {7'd0, tx_go}, 8'h01);

    // R7 transmit done
    wr(2'd0, 8'hED);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0);
    rd(2'd1, v); chk("R7 txrq cleared", v, 8'h56);
    chk("R7 irq txie on", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'hD5); wr(2'd1, 8'hEF);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R7 irq txie off", {7'd0, irq}, 8'h00);
    rd(2'd1, v); chk("R7 txrq cleared 2", v, 8'h56);

    // R8 remote frame
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1);
    rd(2'd1, v); chk("R8 rmtp", v, 8'h96);
    chk("R8 irq rxie off", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'hFB); wr(2'd1, 8'h7F);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R8 irq rxie on", {7'd0, irq}, 8'h01);
    rd(2'd1, v); chk("R8 rmtp 2", v, 8'h96);

    // R11 collisions
    step(1'b1, 2'd1, 8'hFD, 1'b1, 1'b0, 1'b0);
    rd(2'd1, v); chk("R11 cpu clear wins", v, 8'h95);
    step(1'b1, 2'd1, 8'hFF, 1'b1, 1'b0, 1'b0);
    rd(2'd1, v); chk("R11 keep lets event", v, 8'h96);
    step(1'b1, 2'd1, 8'hEF, 1'b0, 1'b1, 1'b0);
    rd(2'd1, v); chk("R11 cpu set wins", v, 8'hA6);

    // R9 sweep
    for (int c = 0; c < 16; c++) begin
      logic mv, dr, tq, up;
      {mv, dr, tq, up} = 4'(c);
      wr(2'd0, {mv ? 2'b10 : 2'b01, 6'b111111});
      wr(2'd2, {4'h0, dr, 3'b000});
      wr(2'd1, {2'b11, tq ? 2'b10 : 2'b01, up ? 2'b10 : 2'b01, 2'b11});
      chk("R9 sweep", {7'd0, tx_go}, {7'd0, mv & dr & tq & ~up});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule